// File: doc/BRIEF.md
# Slot-Table Task Dispatcher

This block divides time into equal slots and starts at most one task in each slot. A clock divider produces a slot tick every `TICK_DIV` clock cycles. The default of 122070 cycles gives roughly 1024 ticks per second from a 125 MHz clock. A slot counter steps through `SLOTS` positions and wraps, so one pass of the counter is one frame. With 64 slots a frame repeats 16 times per second.

Each slot position has an entry in a writable table. An entry either names a task or is marked empty. On a tick, the entry for the new slot is looked up. If it names a task whose enable bit is set, a one-cycle start strobe goes out on that task's line. Operating modes are handled outside the block: they change only the enable mask and never the table.

The table has two copies. Writes from the register port land in a staging copy. The staging copy is transferred to the live copy as slot 0 begins, so a frame always runs on one consistent schedule.

The block keeps track of the task it last started. If that task has not signalled completion by the following tick, the block raises an overrun pulse and increments a saturating overrun counter.

Top module: `slot_dispatcher`

## Requirements
- R1: `slot_tick` is a one-cycle pulse. It occurs every `TICK_DIV` cycles, the first one on the `TICK_DIV`-th rising edge after reset is released.
- R2: `slot_idx` advances by one on every tick and wraps from `SLOTS-1` to 0. `frame_start` pulses together with the tick that enters slot 0, and at no other time.
- R3: A table entry holds a valid flag in its top bit (bit 4 by default) and a task number in its low bits (bits 3:0). When the new slot's entry is valid and that task's enable bit is set, `task_start` carries a single bit, at the task number's position, in the same cycle as `slot_tick`.
- R4: A slot whose entry has the valid flag clear produces no start strobe, whatever task number the entry holds.
- R5: A slot whose task has its enable bit clear produces no start strobe.
- R6: Table writes go to the staging copy only. They become visible at the next entry into slot 0. Slots later in the current frame keep the old schedule.
- R7: A write to the enable mask applies to every tick after the cycle in which it is written.
- R8: If the last started task has not raised its `task_done` bit by the edge of the next tick, `overrun` pulses with that tick. A done bit raised on the tick edge itself counts as completed in time. Done bits of other tasks are ignored.
- R9: `overrun_count` increments by one on each overrun, saturates at its maximum value, and holds its value at all other times.
- R10: During reset all outputs are zero, every table entry is empty and all enable bits are clear. The first tick after reset enters slot 0.
- R11: `task_start` has at most one bit set and is never nonzero outside a tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Write strobe for the staging table |
| tbl_addr | input | SLOT_W | Slot position to write |
| tbl_wdata | input | ID_W+1 | Entry: valid flag in the top bit, task number below |
| en_we | input | 1 | Write strobe for the enable mask |
| en_wdata | input | TASKS | New enable mask, one bit per task |
| task_done | input | TASKS | Completion pulses from the tasks |
| slot_tick | output | 1 | Pulse at every slot boundary |
| slot_idx | output | SLOT_W | Current slot number |
| frame_start | output | 1 | Pulse when slot 0 begins |
| task_start | output | TASKS | One-hot start strobe |
| overrun | output | 1 | Pulse when a task is late at a tick |
| overrun_count | output | CNT_W | Saturating overrun total |

## Verification
Two events can land in the same tick cycle. A tick can both judge the previous task late and launch the next task. A completion can also arrive on the very edge that carries the tick. The bench provokes both with a responder whose reply delay is swept: one cycle short of the slot length, equal to the slot length, and never. A reference model then decides, from the done value captured at the tick edge, whether an overrun is due while the new strobe still fires. Staging writes that cross slot 0, and enable writes made mid-frame, are judged against the model's own two-copy table.

// File: rtl/slot_disp_pkg.sv
package slot_disp_pkg;

  // Successor of a position in a ring of `count` positions.
  function automatic int unsigned ring_next(int unsigned cur, int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

  // Saturating increment for an unsigned value bounded by `maxv`.
  function automatic int unsigned sat_inc(int unsigned cur, int unsigned maxv);
    return (cur >= maxv) ? maxv : cur + 1;
  endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int TICK_DIV = 122070,
  parameter int SLOTS    = 64,
  parameter int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick_now,
  output logic [SLOT_W-1:0] nxt_slot
);
  import slot_disp_pkg::*;

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0]  div_q;
  logic [SLOT_W-1:0] slot_q;

  assign tick_now = (div_q == DIV_W'(TICK_DIV - 1));
  assign nxt_slot = SLOT_W'(ring_next(int'(slot_q), SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      slot_q <= SLOT_W'(SLOTS - 1);   // first tick lands on slot 0
    end else if (tick_now) begin
      div_q  <= '0;
      slot_q <= nxt_slot;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int SLOTS  = 64,
  parameter int ENT_W  = 5,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic [ENT_W-1:0]  wr_data,
  input  logic              commit,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ENT_W-1:0]  rd_entry
);
  logic [ENT_W-1:0] stage_q [SLOTS];
  logic [ENT_W-1:0] live_q  [SLOTS];

  // On the committing edge the live copy is about to be replaced, so the
  // lookup for that slot reads straight from the staging copy.
  assign rd_entry = commit ? stage_q[rd_slot] : live_q[rd_slot];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
        live_q[s]  <= '0;
      end else begin
        if (wr_en && wr_addr == SLOT_W'(s)) stage_q[s] <= wr_data;
        if (commit)                         live_q[s]  <= stage_q[s];
      end
    end
  end
endmodule

// File: rtl/overrun_monitor.sv
module overrun_monitor #(
  parameter int TASKS = 16,
  parameter int ID_W  = $clog2(TASKS),
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             launch,
  input  logic [ID_W-1:0]  launch_id,
  input  logic [TASKS-1:0] task_done,
  output logic             busy_at_tick,
  output logic             overrun_q,
  output logic [CNT_W-1:0] count_q
);
  import slot_disp_pkg::*;

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic            pend_q;
  logic [ID_W-1:0] pid_q;
  logic            done_hit;

  assign done_hit     = pend_q && task_done[pid_q];
  assign busy_at_tick = tick && pend_q && !done_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pid_q     <= '0;
      overrun_q <= 1'b0;
      count_q   <= '0;
    end else begin
      overrun_q <= busy_at_tick;
      if (busy_at_tick) count_q <= CNT_W'(sat_inc(int'(count_q), CNT_MAX));
      if (tick) begin
        pend_q <= launch;
        pid_q  <= launch_id;
      end else if (done_hit) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slot_dispatcher.sv
module slot_dispatcher #(
  parameter int TICK_DIV = 122070,
  parameter int SLOTS    = 64,
  parameter int TASKS    = 16,
  parameter int CNT_W    = 8,
  parameter int SLOT_W   = $clog2(SLOTS),
  parameter int ID_W     = $clog2(TASKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_addr,
  input  logic [ID_W:0]     tbl_wdata,
  input  logic              en_we,
  input  logic [TASKS-1:0]  en_wdata,
  input  logic [TASKS-1:0]  task_done,
  output logic              slot_tick,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              frame_start,
  output logic [TASKS-1:0]  task_start,
  output logic              overrun,
  output logic [CNT_W-1:0]  overrun_count
);
  localparam int ENT_W = ID_W + 1;

  // Named internal events, also observed by the bound checker.
  logic              tick_now;
  logic              commit_now;
  logic              launch_now;
  logic              busy_at_tick;
  logic [SLOT_W-1:0] nxt_slot;
  logic [ENT_W-1:0]  entry;
  logic [ID_W-1:0]   entry_id;
  logic [TASKS-1:0]  en_q;

  slot_timer #(.TICK_DIV(TICK_DIV), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_now(tick_now), .nxt_slot(nxt_slot)
  );

  assign commit_now = tick_now && (nxt_slot == '0);

  slot_table #(.SLOTS(SLOTS), .ENT_W(ENT_W), .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_wdata),
    .commit(commit_now), .rd_slot(nxt_slot), .rd_entry(entry)
  );

  assign entry_id   = entry[ID_W-1:0];
  assign launch_now = tick_now && entry[ENT_W-1]
                      && (int'(entry_id) < TASKS) && en_q[entry_id];

  overrun_monitor #(.TASKS(TASKS), .ID_W(ID_W), .CNT_W(CNT_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .tick(tick_now),
    .launch(launch_now), .launch_id(entry_id), .task_done(task_done),
    .busy_at_tick(busy_at_tick), .overrun_q(overrun), .count_q(overrun_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      slot_tick   <= 1'b0;
      slot_idx    <= '0;
      frame_start <= 1'b0;
      task_start  <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      slot_tick   <= tick_now;
      frame_start <= commit_now;
      task_start  <= launch_now ? (TASKS'(1) << entry_id) : '0;
      if (tick_now) slot_idx <= nxt_slot;
    end
  end
endmodule

// File: rtl/slot_dispatcher_chk.sv
module slot_dispatcher_chk #(
  parameter int TICK_DIV = 8,
  parameter int SLOTS    = 64,
  parameter int TASKS    = 16,
  parameter int CNT_W    = 8,
  parameter int SLOT_W   = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_tick,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              frame_start,
  input logic [TASKS-1:0]  task_start,
  input logic              overrun,
  input logic [CNT_W-1:0]  overrun_count,
  input logic              tick_now,
  input logic              commit_now,
  input logic              busy_at_tick
);
  localparam int GAP_W = $clog2(TICK_DIV + 1) + 1;

  logic [GAP_W-1:0]  gap_q;
  logic              seen_q;
  logic [SLOT_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (slot_tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
      last_q <= slot_idx;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && seen_q) |-> (gap_q == GAP_W'(TICK_DIV - 1)));
  p_tick_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_now |=> slot_tick);
  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && seen_q) |->
      (slot_idx == ((last_q == SLOT_W'(SLOTS - 1)) ? '0 : last_q + 1'b1)));
  p_frame_slot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_tick && slot_idx == '0));
  p_commit_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_now |=> frame_start);
  p_start_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(task_start));
  p_start_in_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|task_start) |-> slot_tick);
  p_overrun_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_at_tick |=> overrun);
  p_overrun_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> slot_tick);
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !overrun |-> $stable(overrun_count));
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ((overrun_count == $past(overrun_count) + 1'b1)
                 || ($past(overrun_count) == {CNT_W{1'b1}}
                     && overrun_count == {CNT_W{1'b1}})));
endmodule

bind slot_dispatcher slot_dispatcher_chk #(
  .TICK_DIV(TICK_DIV), .SLOTS(SLOTS), .TASKS(TASKS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .slot_idx(slot_idx),
  .frame_start(frame_start), .task_start(task_start), .overrun(overrun),
  .overrun_count(overrun_count), .tick_now(tick_now), .commit_now(commit_now),
  .busy_at_tick(busy_at_tick)
);

// File: tb/tb_slot_dispatcher.sv
module tb_slot_dispatcher;
  localparam int TICK_DIV = 8;
  localparam int SLOTS    = 64;
  localparam int TASKS    = 16;
  localparam int CNT_W    = 3;
  localparam int SLOT_W   = 6;
  localparam int ID_W     = 4;
  localparam int FRAME    = SLOTS * TICK_DIV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tbl_we = 1'b0;
  logic [SLOT_W-1:0] tbl_addr = '0;
  logic [ID_W:0]     tbl_wdata = '0;
  logic              en_we = 1'b0;
  logic [TASKS-1:0]  en_wdata = '0;
  logic [TASKS-1:0]  task_done = '0;
  logic              slot_tick, frame_start, overrun;
  logic [SLOT_W-1:0] slot_idx;
  logic [TASKS-1:0]  task_start;
  logic [CNT_W-1:0]  overrun_count;

  slot_dispatcher #(.TICK_DIV(TICK_DIV), .SLOTS(SLOTS), .TASKS(TASKS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .en_we(en_we), .en_wdata(en_wdata),
    .task_done(task_done), .slot_tick(slot_tick), .slot_idx(slot_idx),
    .frame_start(frame_start), .task_start(task_start), .overrun(overrun),
    .overrun_count(overrun_count)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  string phase = "R3";

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- input capture at the active edge ----------------
  logic              c_rst, c_twe, c_ewe;
  logic [SLOT_W-1:0] c_taddr;
  logic [ID_W:0]     c_tdat;
  logic [TASKS-1:0]  c_edat, c_done;
  always @(posedge clk) begin
    c_rst = rst_n; c_twe = tbl_we; c_taddr = tbl_addr; c_tdat = tbl_wdata;
    c_ewe = en_we; c_edat = en_wdata; c_done = task_done;
  end

  // ---------------- reference model (driver side of scoreboard) -----
  typedef struct packed {
    logic              tick;
    logic [SLOT_W-1:0] idx;
    logic              frame;
    logic [TASKS-1:0]  start;
    logic              ovr;
    logic [CNT_W-1:0]  cnt;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];

  logic [ID_W:0]     m_stage [SLOTS];
  logic [ID_W:0]     m_live  [SLOTS];
  logic [TASKS-1:0]  m_en;
  int                m_div, m_slot, m_cnt, m_pid;
  bit                m_pend;
  logic [SLOT_W-1:0] m_idx;

  always @(negedge clk) begin
    exp_t e;
    if (!c_rst) begin
      m_div = 0; m_slot = SLOTS - 1; m_en = '0; m_pend = 0; m_cnt = 0; m_pid = 0;
      m_idx = '0;
      for (int s = 0; s < SLOTS; s++) begin m_stage[s] = '0; m_live[s] = '0; end
    end else begin
      e = '0;
      if (m_div == TICK_DIV - 1) begin
        logic [ID_W:0] ent;
        int nx;
        m_div = 0;
        nx = (m_slot + 1) % SLOTS;
        ent = (nx == 0) ? m_stage[0] : m_live[nx];
        if (nx == 0) for (int s = 0; s < SLOTS; s++) m_live[s] = m_stage[s];
        e.tick = 1; e.frame = (nx == 0);
        e.ovr = m_pend && !c_done[m_pid];
        if (e.ovr && m_cnt < (1 << CNT_W) - 1) m_cnt++;
        m_pend = ent[ID_W] && m_en[ent[ID_W-1:0]];
        m_pid = int'(ent[ID_W-1:0]);
        if (m_pend) e.start = TASKS'(1) << m_pid;
        m_slot = nx;
        m_idx = SLOT_W'(nx);
      end else begin
        m_div++;
        if (m_pend && c_done[m_pid]) m_pend = 0;
      end
      e.idx = m_idx;
      e.cnt = CNT_W'(m_cnt);
      if (c_twe) m_stage[c_taddr] = c_tdat;
      if (c_ewe) m_en = c_edat;
      expq.push_back(e);
      tagq.push_back(phase);
    end
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    #1;
    while (expq.size() > 0) begin
      exp_t  e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(slot_tick == e.tick, "R1", "slot_tick", 64'(slot_tick), 64'(e.tick));
      chk(slot_idx == e.idx, "R2", "slot_idx", 64'(slot_idx), 64'(e.idx));
      chk(frame_start == e.frame, "R2", "frame_start", 64'(frame_start), 64'(e.frame));
      if (e.tick)
        chk(task_start == e.start, t, "task_start", 64'(task_start), 64'(e.start));
      else
        chk(task_start == '0, "R11", "task_start off tick", 64'(task_start), 64'(0));
      chk(overrun == e.ovr, "R8", "overrun", 64'(overrun), 64'(e.ovr));
      chk(overrun_count == e.cnt, "R9", "overrun_count", 64'(overrun_count), 64'(e.cnt));
    end
  end

  // ---------------- task responder ----------------
  int ack_delay = 3;     // negative: never reply
  bit spur = 0;          // also raise the done bit of an unrelated task
  bit rsp_on = 0;
  int rsp_id = 0, rsp_k = 0;
  always @(negedge clk) begin
    task_done = '0;
    if (|task_start) begin
      rsp_on = 1; rsp_k = 0;
      for (int i = 0; i < TASKS; i++) if (task_start[i]) rsp_id = i;
    end else if (rsp_on) rsp_k++;
    if (rsp_on && ack_delay >= 0 && rsp_k == ack_delay) begin
      task_done[rsp_id] = 1'b1;
      rsp_on = 0;
    end
    if (spur) task_done[(rsp_id + 1) % TASKS] = 1'b1;
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_tbl(int slot, bit valid, int id);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = SLOT_W'(slot); tbl_wdata = {valid, ID_W'(id)};
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wr_en(logic [TASKS-1:0] m);
    @(negedge clk);
    en_we = 1'b1; en_wdata = m;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic wait_slot(int s);
    do @(negedge clk); while (!(slot_tick && slot_idx == SLOT_W'(s)));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    chk(slot_tick == 0, "R10", "reset slot_tick", 64'(slot_tick), 0);
    chk(slot_idx == 0, "R10", "reset slot_idx", 64'(slot_idx), 0);
    chk(frame_start == 0, "R10", "reset frame_start", 64'(frame_start), 0);
    chk(task_start == 0, "R10", "reset task_start", 64'(task_start), 0);
    chk(overrun == 0, "R10", "reset overrun", 64'(overrun), 0);
    chk(overrun_count == 0, "R10", "reset overrun_count", 64'(overrun_count), 0);
    rst_n = 1'b1;

    // R3 R4 R5: basic schedule, an empty slot and a disabled task
    phase = "R3 R4 R5";
    wr_en(16'h002C);            // tasks 2, 3, 5 enabled
    wr_tbl(0, 1, 2);
    wr_tbl(1, 0, 3);            // empty, though task 3 is enabled
    wr_tbl(2, 1, 5);
    wr_tbl(3, 1, 7);            // task 7 not enabled
    wr_tbl(5, 1, 2);
    repeat (2 * FRAME) @(negedge clk);

    // R6: mid-frame rewrite only visible from the next slot 0
    phase = "R6";
    wait_slot(10);
    wr_en(16'h022C);
    wr_tbl(2, 1, 9);
    repeat (FRAME + FRAME / 2) @(negedge clk);

    // R7: enable changes mid-frame apply at the next tick
    phase = "R7";
    wait_slot(30);
    wr_en(16'h02AC);            // task 7 on
    wait_slot(4);
    wr_en(16'h02A8);            // task 2 off just before slot 5
    repeat (FRAME) @(negedge clk);
    wr_en(16'h02AC);

    // R8: reply one cycle early, exactly on the tick edge, then late
    phase = "R8";
    ack_delay = TICK_DIV - 2;
    repeat (FRAME) @(negedge clk);
    ack_delay = TICK_DIV - 1;   // done sampled on the tick edge itself
    repeat (FRAME) @(negedge clk);
    ack_delay = TICK_DIV;       // one cycle too late
    repeat (FRAME) @(negedge clk);

    // R9: dense schedule with no replies drives the counter to saturation
    phase = "R9";
    ack_delay = -1;
    spur = 1;
    wr_en({TASKS{1'b1}});
    for (int s = 0; s < SLOTS; s++) wr_tbl(s, 1, s % TASKS);
    repeat (2 * FRAME) @(negedge clk);
    chk(overrun_count == {CNT_W{1'b1}}, "R9", "saturated count",
        64'(overrun_count), 64'({CNT_W{1'b1}}));
    spur = 0;
    ack_delay = 2;
    repeat (FRAME) @(negedge clk);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule